// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether a single memory access may proceed, given a set of protection entries whose address bounds have already been decoded into an inclusive low and high byte address. Each request carries a start address, a byte count, the permissions it needs (read, write, execute) and the privilege mode of the requester. Along with the verdict, the block reports the permission mask that governed the decision.

Entries are searched in a fixed priority order, from the lowest index up. An access that straddles the edge of the deciding entry is refused outright. Two global policy inputs change the rules:

- A lockdown bit switches the per-entry rules to a pair of 16-entry truth tables, one for machine mode and one for the lower modes.
- A whitelist bit refuses every access that no entry claims.

The decision is combinational from the request inputs. It is captured in a register, so the verdict appears one clock after the request. A core's load/store or fetch path uses it to raise a fault.

Top module: `pmp_access_checker`

## Requirements
- R1: Only entries with their `ent_on` bit set take part. Among those, the lowest-indexed entry whose range holds the first byte or the last byte of the access decides the result, and all higher entries are ignored.
- R2: If exactly one of the first byte and the last byte lies inside the deciding entry, the access is refused with a zero mask. This holds whatever the mode, the lockdown bit and the entry permissions are.
- R3: With lockdown clear and the access fully inside the deciding entry, the mask is read 001, write 010 and execute 100 (bit0 read, bit1 write, bit2 execute). A machine-mode access to an entry whose lock bit is clear gets mask 111. Any other access gets the entry's own permission bits. `ent_cfg[i]` holds {lock[3], read[2], write[1], execute[0]}.
- R4: With lockdown set, a machine-mode access fully inside the deciding entry is looked up by code {lock,read,write,execute}:
  - codes 2, 3 and 14 give 011;
  - codes 9 and 10 give 100;
  - codes 11 and 13 give 101;
  - codes 12 and 15 give 001;
  - every other code gives 000.
- R5: With lockdown set, a lower-mode access fully inside the deciding entry is looked up by the same code:
  - codes 1, 10 and 11 give 100;
  - codes 2, 4 and 15 give 001;
  - codes 3 and 6 give 011;
  - code 5 gives 101;
  - code 7 gives 111;
  - every other code gives 000.
- R6: When an entry decides without a partial overlap, the access is allowed only if every requested permission bit is also set in the mask.
- R7: When no entry decides and the whitelist bit is set, the access is refused with mask 000. When no entry decides, the whitelist bit is clear and the lockdown bit is set, a machine-mode access that does not request execute is allowed with mask 011. Every other access in that case is refused with mask 000.
- R8: When no entry decides and both the whitelist and lockdown bits are clear, a machine-mode access is allowed with mask 111. A lower-mode access is refused with mask 000.
- R9: The last byte is `req_addr + size - 1`, where a `req_size` of zero counts as 4 bytes.
- R10: Mode value 2'b11 is machine mode. Every other mode value is treated as a lower privilege.
- R11: `rsp_valid` follows `req_valid` one clock later, and the verdict and mask belong to that request. While `rsp_valid` is low, `rsp_allow` and `rsp_mask` are zero. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Byte count; zero means 4 |
| req_perm | input | 3 | Requested permissions {execute, write, read} |
| req_mode | input | 2 | Privilege mode; 2'b11 is machine |
| lockdown_en | input | 1 | Selects the lockdown truth tables and default |
| whitelist_en | input | 1 | Refuse every unclaimed access |
| ent_lo | input | NUM_ENTRIES x ADDR_W | Inclusive low byte address per entry |
| ent_hi | input | NUM_ENTRIES x ADDR_W | Inclusive high byte address per entry |
| ent_cfg | input | NUM_ENTRIES x 4 | Per entry {lock, read, write, execute} |
| ent_on | input | NUM_ENTRIES | Entry takes part in matching |
| rsp_valid | output | 1 | Verdict is valid |
| rsp_allow | output | 1 | Access is allowed |
| rsp_mask | output | 3 | Governing permission mask {execute, write, read} |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing and the quiet outputs while idle;
- that an allowed verdict never exceeds its mask;
- that a whitelisted unclaimed access is refused;
- that an unclaimed machine access with both policy bits clear gets full rights;
- that machine mode under lockdown never holds all three rights.

Only the bench scenarios can show the rest:
- priority between overlapping entries;
- refusal on a straddled edge, including the zero-size case;
- the exact truth-table entries for each code and mode;
- that a disabled entry covering the address changes nothing.

// File: rtl/pmp_chk_pkg.sv
`timescale 1ns/1ps
package pmp_chk_pkg;

    localparam logic [1:0] PRIV_MACH = 2'b11;

    // Permission vector: bit0 read, bit1 write, bit2 execute
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    // Entry rule code: {lock, read, write, execute}
    typedef struct packed {
        logic lock;
        logic r;
        logic w;
        logic x;
    } rule_code_t;

    typedef enum logic [1:0] {
        SRC_DEFAULT = 2'b00,
        SRC_ENTRY   = 2'b01,
        SRC_PARTIAL = 2'b10
    } verdict_src_e;

    typedef struct packed {
        logic  allow;
        perm_t mask;
    } verdict_t;

    localparam perm_t P_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};
    localparam perm_t P_R    = '{x: 1'b0, w: 1'b0, r: 1'b1};
    localparam perm_t P_X    = '{x: 1'b1, w: 1'b0, r: 1'b0};
    localparam perm_t P_RW   = '{x: 1'b0, w: 1'b1, r: 1'b1};
    localparam perm_t P_RX   = '{x: 1'b1, w: 1'b0, r: 1'b1};
    localparam perm_t P_RWX  = '{x: 1'b1, w: 1'b1, r: 1'b1};

    function automatic logic is_machine(input logic [1:0] mode);
        return mode == PRIV_MACH;
    endfunction

    // Every requested bit must be granted
    function automatic logic covers(input perm_t want, input perm_t have);
        return (want & ~have) == P_NONE;
    endfunction

    // Lockdown table, machine mode
    function automatic perm_t lock_table_mach(input rule_code_t c);
        logic [3:0] k;
        k = c;
        case (k)
            4'd2, 4'd3, 4'd14: return P_RW;
            4'd9, 4'd10:       return P_X;
            4'd11, 4'd13:      return P_RX;
            4'd12, 4'd15:      return P_R;
            default:           return P_NONE;
        endcase
    endfunction

    // Lockdown table, lower privilege modes
    function automatic perm_t lock_table_low(input rule_code_t c);
        logic [3:0] k;
        k = c;
        case (k)
            4'd1, 4'd10, 4'd11: return P_X;
            4'd2, 4'd4, 4'd15:  return P_R;
            4'd3, 4'd6:         return P_RW;
            4'd5:               return P_RX;
            4'd7:               return P_RWX;
            default:            return P_NONE;
        endcase
    endfunction

    // Rules used while lockdown is clear
    function automatic perm_t classic_rule(input rule_code_t c, input logic mach);
        if (mach && !c.lock) begin
            return P_RWX;
        end
        return '{x: c.x, w: c.w, r: c.r};
    endfunction

    // Verdict when no entry claims the access
    function automatic verdict_t default_verdict(input logic whitelist, input logic lockdown,
                                                 input logic mach, input perm_t want);
        verdict_t v;
        v = '{allow: 1'b0, mask: P_NONE};
        if (whitelist) begin
            v = '{allow: 1'b0, mask: P_NONE};
        end else if (lockdown) begin
            if (mach && !want.x) begin
                v = '{allow: 1'b1, mask: P_RW};
            end
        end else if (mach) begin
            v = '{allow: 1'b1, mask: P_RWX};
        end
        return v;
    endfunction

endpackage

// File: rtl/pmp_range_match.sv
`timescale 1ns/1ps
module pmp_range_match #(
    parameter int NUM = 8,
    parameter int AW  = 32
) (
    input  logic [AW-1:0]           first_byte,
    input  logic [AW-1:0]           last_byte,
    input  logic [NUM-1:0][AW-1:0]  lo_bound,
    input  logic [NUM-1:0][AW-1:0]  hi_bound,
    output logic [NUM-1:0]          first_in,
    output logic [NUM-1:0]          last_in
);

    // One pair of inclusive window compares per entry
    for (genvar g = 0; g < NUM; g++) begin : g_ent
        assign first_in[g] = (first_byte >= lo_bound[g]) && (first_byte <= hi_bound[g]);
        assign last_in[g]  = (last_byte  >= lo_bound[g]) && (last_byte  <= hi_bound[g]);
    end

endmodule

// File: rtl/pmp_priority_pick.sv
`timescale 1ns/1ps
module pmp_priority_pick #(
    parameter int NUM = 8,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] first_in,
    input  logic [NUM-1:0] last_in,
    input  logic [NUM-1:0] ent_on,
    output logic           hit,
    output logic           partial,
    output logic [IW-1:0]  hit_idx
);

    logic [NUM-1:0] touch;

    assign touch = ent_on & (first_in | last_in);

    // Scan downward so the lowest touching index is written last
    always_comb begin
        hit     = 1'b0;
        partial = 1'b0;
        hit_idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (touch[i]) begin
                hit     = 1'b1;
                partial = first_in[i] ^ last_in[i];
                hit_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pmp_rule_eval.sv
`timescale 1ns/1ps
module pmp_rule_eval
    import pmp_chk_pkg::*;
(
    input  logic        hit,
    input  logic        partial,
    input  rule_code_t  code,
    input  logic [1:0]  mode,
    input  logic        lockdown,
    input  logic        whitelist,
    input  perm_t       want,
    output verdict_t    verdict
);

    verdict_src_e src;
    perm_t        entry_mask;
    logic         mach;

    assign mach = is_machine(mode);

    always_comb begin
        if (!hit) begin
            src = SRC_DEFAULT;
        end else if (partial) begin
            src = SRC_PARTIAL;
        end else begin
            src = SRC_ENTRY;
        end
    end

    always_comb begin
        if (!lockdown) begin
            entry_mask = classic_rule(code, mach);
        end else if (mach) begin
            entry_mask = lock_table_mach(code);
        end else begin
            entry_mask = lock_table_low(code);
        end
    end

    always_comb begin
        case (src)
            SRC_ENTRY:   verdict = '{allow: covers(want, entry_mask), mask: entry_mask};
            SRC_PARTIAL: verdict = '{allow: 1'b0, mask: P_NONE};
            default:     verdict = default_verdict(whitelist, lockdown, mach, want);
        endcase
    end

endmodule

// File: rtl/pmp_access_checker.sv
`timescale 1ns/1ps
module pmp_access_checker
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [SIZE_W-1:0]                  req_size,
    input  logic [2:0]                         req_perm,
    input  logic [1:0]                         req_mode,
    input  logic                               lockdown_en,
    input  logic                               whitelist_en,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_lo,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_hi,
    input  logic [NUM_ENTRIES-1:0][3:0]        ent_cfg,
    input  logic [NUM_ENTRIES-1:0]             ent_on,
    output logic                               rsp_valid,
    output logic                               rsp_allow,
    output logic [2:0]                         rsp_mask
);

    localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [ADDR_W-1:0] ZERO_SIZE_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0]      eff_size;
    logic [ADDR_W-1:0]      last_byte;
    logic [NUM_ENTRIES-1:0] first_in;
    logic [NUM_ENTRIES-1:0] last_in;
    logic                   pick_hit;
    logic                   pick_partial;
    logic [IW-1:0]          pick_idx;
    rule_code_t             pick_code;
    verdict_t               verdict;

    // A zero byte count stands for a 4-byte access
    assign eff_size  = (req_size == '0) ? ZERO_SIZE_BYTES : ADDR_W'(req_size);
    assign last_byte = req_addr + eff_size - ADDR_W'(1);

    pmp_range_match #(
        .NUM (NUM_ENTRIES),
        .AW  (ADDR_W)
    ) u_match (
        .first_byte (req_addr),
        .last_byte  (last_byte),
        .lo_bound   (ent_lo),
        .hi_bound   (ent_hi),
        .first_in   (first_in),
        .last_in    (last_in)
    );

    pmp_priority_pick #(
        .NUM (NUM_ENTRIES)
    ) u_pick (
        .first_in (first_in),
        .last_in  (last_in),
        .ent_on   (ent_on),
        .hit      (pick_hit),
        .partial  (pick_partial),
        .hit_idx  (pick_idx)
    );

    assign pick_code = rule_code_t'(ent_cfg[pick_idx]);

    pmp_rule_eval u_eval (
        .hit       (pick_hit),
        .partial   (pick_partial),
        .code      (pick_code),
        .mode      (req_mode),
        .lockdown  (lockdown_en),
        .whitelist (whitelist_en),
        .want      (perm_t'(req_perm)),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_mask  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_allow <= verdict.allow;
                rsp_mask  <= verdict.mask;
            end else begin
                rsp_allow <= 1'b0;
                rsp_mask  <= '0;
            end
        end
    end

endmodule

// File: rtl/pmp_access_checker_sva.sv
`timescale 1ns/1ps
module pmp_access_checker_sva (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_perm,
    input logic [1:0] req_mode,
    input logic       lockdown_en,
    input logic       whitelist_en,
    input logic       any_hit,
    input logic       rsp_valid,
    input logic       rsp_allow,
    input logic [2:0] rsp_mask
);

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_allow && rsp_mask == 3'b000);

    // R6
    allow_within_mask_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_allow || (($past(req_perm) & ~rsp_mask) == 3'b000)));

    // R7
    whitelist_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && whitelist_en && !any_hit) |=> (!rsp_allow && rsp_mask == 3'b000));

    // R8
    mach_open_default_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !whitelist_en && !lockdown_en && req_mode == 2'b11 && !any_hit)
        |=> (rsp_allow && rsp_mask == 3'b111));

    // R4
    mach_lockdown_no_full_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lockdown_en && req_mode == 2'b11) |=> rsp_mask != 3'b111);

endmodule

bind pmp_access_checker pmp_access_checker_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_perm     (req_perm),
    .req_mode     (req_mode),
    .lockdown_en  (lockdown_en),
    .whitelist_en (whitelist_en),
    .any_hit      (pick_hit),
    .rsp_valid    (rsp_valid),
    .rsp_allow    (rsp_allow),
    .rsp_mask     (rsp_mask)
);

// File: tb/sim_pmp_access_checker.sv
`timescale 1ns/1ps
module sim_pmp_access_checker;

    localparam logic [2:0] PR = 3'b001;
    localparam logic [2:0] PW = 3'b010;
    localparam logic [2:0] PX = 3'b100;
    localparam logic [1:0] MM = 2'b11;
    localparam logic [1:0] UM = 2'b00;

    typedef struct {
        logic       allow;
        logic [2:0] mask;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [3:0]        req_size = '0;
    logic [2:0]        req_perm = '0;
    logic [1:0]        req_mode = '0;
    logic              lockdown_en = 1'b0;
    logic              whitelist_en = 1'b0;
    logic [7:0][31:0]  ent_lo = '0;
    logic [7:0][31:0]  ent_hi = '0;
    logic [7:0][3:0]   ent_cfg = '0;
    logic [7:0]        ent_on = '0;
    logic              rsp_valid;
    logic              rsp_allow;
    logic [2:0]        rsp_mask;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pmp_access_checker u0 (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_perm     (req_perm),
        .req_mode     (req_mode),
        .lockdown_en  (lockdown_en),
        .whitelist_en (whitelist_en),
        .ent_lo       (ent_lo),
        .ent_hi       (ent_hi),
        .ent_cfg      (ent_cfg),
        .ent_on       (ent_on),
        .rsp_valid    (rsp_valid),
        .rsp_allow    (rsp_allow),
        .rsp_mask     (rsp_mask)
    );

    task automatic access(input logic [31:0] a, input logic [3:0] sz, input logic [2:0] p,
                          input logic [1:0] m, input logic e_allow, input logic [2:0] e_mask,
                          input string tag);
        exp_t e;
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        req_perm  = p;
        req_mode  = m;
        e.allow = e_allow;
        e.mask  = e_mask;
        e.tag   = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares each response against the oldest expected item
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R11: unexpected response allow=%0b mask=%03b expected none",
                         rsp_allow, rsp_mask);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_allow !== e.allow || rsp_mask !== e.mask) begin
                    n_fails++;
                    $display("FAIL %s: allow=%0b mask=%03b expected allow=%0b mask=%03b",
                             e.tag, rsp_allow, rsp_mask, e.allow, e.mask);
                end
            end
        end
    end

    initial begin
        // Entry table
        ent_lo[0] = 32'h1000; ent_hi[0] = 32'h10FF; ent_cfg[0] = 4'b0100; ent_on[0] = 1'b1;
        ent_lo[1] = 32'h1000; ent_hi[1] = 32'h1FFF; ent_cfg[1] = 4'b0111; ent_on[1] = 1'b1;
        ent_lo[2] = 32'h3000; ent_hi[2] = 32'h3003; ent_cfg[2] = 4'b1101; ent_on[2] = 1'b1;
        ent_lo[3] = 32'h4000; ent_hi[3] = 32'h4FFF; ent_cfg[3] = 4'b0111; ent_on[3] = 1'b0;
        ent_lo[4] = 32'h5000; ent_hi[4] = 32'h5FFF; ent_cfg[4] = 4'b0010; ent_on[4] = 1'b1;
        ent_lo[5] = 32'h6000; ent_hi[5] = 32'h6FFF; ent_cfg[5] = 4'b1010; ent_on[5] = 1'b1;

        // R11: outputs held clear in reset even with a request present
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_mask !== 3'b000) begin
            n_fails++;
            $display("FAIL R11: reset valid=%0b allow=%0b mask=%03b expected 0 0 000",
                     rsp_valid, rsp_allow, rsp_mask);
        end
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // Lockdown and whitelist clear
        access(32'h1010, 4'd4, PR, UM, 1'b1, 3'b001, "R1 R3 lower read entry0");
        access(32'h1010, 4'd4, PW, UM, 1'b0, 3'b001, "R6 lower write refused");
        access(32'h1010, 4'd4, PW, MM, 1'b1, 3'b111, "R3 machine unlocked full");
        access(32'h1200, 4'd4, PW, UM, 1'b1, 3'b111, "R1 falls to entry1");
        access(32'h10FE, 4'd4, PR, UM, 1'b0, 3'b000, "R2 straddle entry0 edge");
        access(32'h10FC, 4'd0, PR, UM, 1'b1, 3'b001, "R9 zero size fits");
        access(32'h10FE, 4'd0, PR, UM, 1'b0, 3'b000, "R9 zero size straddles");
        access(32'h3000, 4'd4, PX, MM, 1'b1, 3'b101, "R3 machine locked exec");
        access(32'h3000, 4'd4, PW, MM, 1'b0, 3'b101, "R3 machine locked write");
        access(32'h4010, 4'd4, PR, UM, 1'b0, 3'b000, "R8 R1 lower unclaimed, disabled entry");
        access(32'h4010, 4'd4, PX, MM, 1'b1, 3'b111, "R8 machine unclaimed");
        access(32'h1010, 4'd4, PW, 2'b10, 1'b0, 3'b001, "R10 mode 10 is lower");
        access(32'h1010, 4'd4, PW, 2'b01, 1'b0, 3'b001, "R10 mode 01 is lower");
        access(32'h5000, 4'd4, PW, UM, 1'b1, 3'b010, "R3 lower write-only entry");

        // Lockdown set
        lockdown_en = 1'b1;
        access(32'h3000, 4'd4, PX, MM, 1'b1, 3'b101, "R4 code 13 machine");
        access(32'h3000, 4'd4, PR, UM, 1'b0, 3'b000, "R5 code 13 lower");
        access(32'h1010, 4'd4, PR, UM, 1'b1, 3'b001, "R5 code 4 lower");
        access(32'h1010, 4'd4, PR, MM, 1'b0, 3'b000, "R4 code 4 machine");
        access(32'h1200, 4'd4, PR, MM, 1'b0, 3'b000, "R4 code 7 machine");
        access(32'h1200, 4'd4, PX, UM, 1'b1, 3'b111, "R5 code 7 lower");
        access(32'h5000, 4'd4, PW, MM, 1'b1, 3'b011, "R4 code 2 machine");
        access(32'h5000, 4'd4, PW, UM, 1'b0, 3'b001, "R5 code 2 lower");
        access(32'h6000, 4'd4, PX, MM, 1'b1, 3'b100, "R4 code 10 machine");
        access(32'h6000, 4'd4, PX, UM, 1'b1, 3'b100, "R5 code 10 lower exec");
        access(32'h6000, 4'd4, PR, UM, 1'b0, 3'b100, "R5 R6 code 10 lower read");
        access(32'h4010, 4'd4, PR, MM, 1'b1, 3'b011, "R7 lockdown machine read default");
        access(32'h4010, 4'd4, PX, MM, 1'b0, 3'b000, "R7 lockdown machine exec default");
        access(32'h4010, 4'd4, PR, UM, 1'b0, 3'b000, "R7 lockdown lower default");
        access(32'h4010, 4'd4, PR, 2'b10, 1'b0, 3'b000, "R10 R7 mode 10 default");
        access(32'h10FE, 4'd4, PR, MM, 1'b0, 3'b000, "R2 straddle under lockdown");

        // Whitelist set
        whitelist_en = 1'b1;
        access(32'h4010, 4'd4, PR, MM, 1'b0, 3'b000, "R7 whitelist machine read");
        access(32'h4010, 4'd4, 3'b000, MM, 1'b0, 3'b000, "R7 whitelist empty request");
        access(32'h3000, 4'd4, PX, MM, 1'b1, 3'b101, "R7 whitelist claimed entry");
        lockdown_en = 1'b0;
        access(32'h4010, 4'd4, PR, MM, 1'b0, 3'b000, "R7 whitelist without lockdown");
        access(32'h1010, 4'd4, PR, UM, 1'b1, 3'b001, "R7 R3 whitelist claimed classic");

        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0 || rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_mask !== 3'b000) begin
            n_fails++;
            $display("FAIL R11: idle pending=%0d valid=%0b allow=%0b mask=%03b expected 0 0 0 000",
                     exp_q.size(), rsp_valid, rsp_allow, rsp_mask);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R11: watchdog expired, got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule